// File: doc/BRIEF.md
# Memory Decoder Commit Register Bank

This block holds a bank of address-range decoder settings that software programs over a plain 32-bit register bus. Each decoder slot stores a 64-bit base, a 64-bit size, a 64-bit auxiliary word and a control word. The auxiliary word is a list of eight 8-bit port numbers on a switch-style bank, or a skip amount on an endpoint-style bank. The control word carries the interleave granularity and way-count codes, an expander/accelerator type flag, a lock flag, and a commit request. It also reports three status flags: pending, committed and error.

Raising the commit request starts a check that runs for a fixed number of cycles (`CHK_CYCLES`). At its end the slot reports either committed or error. The check enforces three things: slots commit in ascending order, base and size sit on 256 MB boundaries, and the way count fits what the bank supports. A slot can only be released when no slot above it is committed. A committed slot with its lock flag set refuses every write. Nothing below the register level is modelled: the bank does not decode memory traffic.

Top module: `dec_commit_bank`

Address map, in 32-bit word addresses:
- Word 0 is the read-only capability word.
- Slot i occupies words 8*(i+1) to 8*(i+1)+7:
  - +0 and +1: base, low and high words.
  - +2 and +3: size, low and high words.
  - +4: control word.
  - +5 and +6: auxiliary word, low and high words.
  - +7: reserved, reads 0.

Control word layout:
- [3:0] granularity code
- [7:4] way code (2^code ways; codes above 3 are invalid)
- [8] type (1 = expander, 0 = accelerator)
- [9] lock
- [10] commit request
- [11] committed (read-only)
- [12] error (read-only)
- [13] pending (read-only)

## Requirements
- R1: After a synchronous reset every slot reads back zero base, size, auxiliary and control words, and `dec_committed` is all zeros.
- R2: Word 0 reads {14'b0, high-interleave flag [17], low-interleave flag [16], target count [15:8], decoder count [7:0]}, which is 0x00030404 with default parameters. Word addresses that map to no slot read 0.
- R3: Base, size and auxiliary words, and control bits [9:0], read back exactly what was written while the slot is neither pending nor committed.
- R4: A write that raises commit sets pending (bit 13) on the next cycle. Committed (bit 11) appears exactly `CHK_CYCLES` clock edges after the write edge and not earlier, and the slot's bit of `dec_committed` rises with it.
- R5: A commit on slot m+1 whose check ends while slot m is not committed ends with error (bit 12) set and committed clear.
- R6: A commit ends with error if base bits [27:0] are not zero, if size is zero, or if size bits [27:0] are not zero.
- R7: Error is sticky. It stays set through further writes of commit=1 and clears only when commit is written 0, which also clears the commit request.
- R8: Writing commit=0 to a committed slot releases it (committed and `dec_committed` bit clear) only if the slot above it is not committed. Otherwise the write leaves the slot committed. Base and size keep their values after release.
- R9: While a slot is committed with lock set, writes to its base, size, auxiliary and control words have no effect, including a release.
- R10: While a slot is pending or committed without lock, writes to its base, size and auxiliary words and to control bits [9:0] are ignored.
- R11: On a switch-style bank a commit ends with error if the way code exceeds 3 or if 2^code exceeds the target count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (6) | Word address for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| dec_committed | output | NUM_DEC (4) | Committed flag of each slot |

## Verification
The hardest situations to reach are the ordering ones: a release refused because a higher slot is committed, and a commit rejected because the slot below is not committed. Both need several slots driven into specific states one after another. The stimulus builds them in sequence. It first fails a commit on slot 2 while slot 1 is idle. It then walks slot 1 through each of its alignment failures before a good commit, commits slot 2, and then attempts releases from the bottom up before unwinding from the top. Lock is checked last, on a slot reached only after that unwinding.

// File: rtl/dcb_pkg.sv
// Package dcb_pkg
// Shared constants and types for the decoder commit bank.
// Assumes 32-bit register words and 64-bit range values.
package dcb_pkg;

    localparam int ALIGN_BITS = 28;   // 256 MB granule
    localparam int MAX_WAYCODE = 3;   // 1,2,4,8 ways

    // word offsets inside one slot window
    localparam logic [2:0] OFF_BASE_LO = 3'd0;
    localparam logic [2:0] OFF_BASE_HI = 3'd1;
    localparam logic [2:0] OFF_SIZE_LO = 3'd2;
    localparam logic [2:0] OFF_SIZE_HI = 3'd3;
    localparam logic [2:0] OFF_CTRL    = 3'd4;
    localparam logic [2:0] OFF_AUX_LO  = 3'd5;
    localparam logic [2:0] OFF_AUX_HI  = 3'd6;

    // control word bit positions
    localparam int B_TYPE = 8;
    localparam int B_LOCK = 9;
    localparam int B_REQ  = 10;
    localparam int B_DONE = 11;
    localparam int B_ERR  = 12;
    localparam int B_PEND = 13;

    typedef struct packed {
        logic       lock;
        logic       xtype;
        logic [3:0] ways;
        logic [3:0] gran;
    } cfg_t;

endpackage

// File: rtl/dcb_rules.sv
// Module dcb_rules
// Combinational pass/fail verdict for one commit attempt.
// Assumes inputs are stable while the slot is pending.
// SWITCH selects the target-list rule, otherwise the skip rule.
module dcb_rules
    import dcb_pkg::*;
#(
    parameter int TGT_CNT = 4,
    parameter bit SWITCH  = 1'b1
) (
    input  logic [63:0] base_i,
    input  logic [63:0] size_i,
    input  logic [63:0] aux_i,
    input  logic [3:0]  ways_i,
    input  logic        prev_done_i,
    output logic        pass_o
);

    logic range_ok;
    logic variant_ok;

    // address range must be non-empty and granule aligned
    always_comb begin
        range_ok = (base_i[ALIGN_BITS-1:0] == '0) &&
                   (size_i != 64'd0) &&
                   (size_i[ALIGN_BITS-1:0] == '0);
    end

    generate
        if (SWITCH) begin : g_switch
            // way count must be a legal code and fit the target list
            always_comb begin
                variant_ok = (ways_i <= 4'(MAX_WAYCODE)) &&
                             ((32'd1 << ways_i) <= $unsigned(TGT_CNT));
            end
        end else begin : g_endpoint
            // skip must be granule aligned and way code legal
            always_comb begin
                variant_ok = (ways_i <= 4'(MAX_WAYCODE)) &&
                             (aux_i[ALIGN_BITS-1:0] == '0);
            end
        end
    endgenerate

    // final verdict includes ascending commit order
    always_comb begin
        pass_o = prev_done_i && range_ok && variant_ok;
    end

endmodule

// File: rtl/dcb_slot.sv
// Module dcb_slot
// One decoder register set with its commit/release state machine.
// Assumes wr_i is already qualified by the slot address window.
// prev_done_i / next_done_i come from the neighbouring slots.
module dcb_slot
    import dcb_pkg::*;
#(
    parameter int CHK_CYCLES = 6,
    parameter int TGT_CNT    = 4,
    parameter bit SWITCH     = 1'b1,
    localparam int CW        = $clog2(CHK_CYCLES + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_i,
    input  logic [2:0]  off_i,
    input  logic [31:0] wdata_i,
    input  logic        prev_done_i,
    input  logic        next_done_i,
    output logic [31:0] rword_o,
    output logic        done_o,
    output logic        pend_o,
    output logic        err_o
);

    logic [63:0] base_q, size_q, aux_q;
    cfg_t        cfg_q;
    logic        req_q, done_q, err_q, pend_q;
    logic [CW-1:0] cnt_q;
    logic        frozen, locked, pass;
    logic        ctrl_wr, new_req;

    assign frozen  = pend_q | done_q;
    assign locked  = done_q & cfg_q.lock;
    assign ctrl_wr = wr_i && (off_i == OFF_CTRL) && !locked;
    assign new_req = wdata_i[B_REQ];

    dcb_rules #(.TGT_CNT(TGT_CNT), .SWITCH(SWITCH)) u_rules (
        .base_i      (base_q),
        .size_i      (size_q),
        .aux_i       (aux_q),
        .ways_i      (cfg_q.ways),
        .prev_done_i (prev_done_i),
        .pass_o      (pass)
    );

    // range and auxiliary words, writable only while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            size_q <= '0;
            aux_q  <= '0;
        end else if (wr_i && !frozen) begin
            case (off_i)
                OFF_BASE_LO: base_q[31:0]  <= wdata_i;
                OFF_BASE_HI: base_q[63:32] <= wdata_i;
                OFF_SIZE_LO: size_q[31:0]  <= wdata_i;
                OFF_SIZE_HI: size_q[63:32] <= wdata_i;
                OFF_AUX_LO:  aux_q[31:0]   <= wdata_i;
                OFF_AUX_HI:  aux_q[63:32]  <= wdata_i;
                default: ;
            endcase
        end
    end

    // configuration fields, writable only while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (ctrl_wr && !frozen) begin
            cfg_q <= cfg_t'(wdata_i[9:0]);
        end
    end

    // commit timer, verdict, release and sticky error
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            pend_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            if (pend_q) begin
                if (cnt_q == CW'(1)) begin
                    pend_q <= 1'b0;
                    done_q <= pass;
                    err_q  <= !pass;
                end else begin
                    cnt_q <= cnt_q - CW'(1);
                end
            end
            if (ctrl_wr) begin
                if (new_req && !req_q) begin
                    req_q  <= 1'b1;
                    pend_q <= 1'b1;
                    cnt_q  <= CW'(CHK_CYCLES);
                end else if (!new_req && req_q) begin
                    if (pend_q || err_q) begin
                        req_q  <= 1'b0;
                        pend_q <= 1'b0;
                        err_q  <= 1'b0;
                    end else if (done_q && !next_done_i) begin
                        req_q  <= 1'b0;
                        done_q <= 1'b0;
                    end
                end
            end
        end
    end

    // read-back of the addressed word
    always_comb begin
        case (off_i)
            OFF_BASE_LO: rword_o = base_q[31:0];
            OFF_BASE_HI: rword_o = base_q[63:32];
            OFF_SIZE_LO: rword_o = size_q[31:0];
            OFF_SIZE_HI: rword_o = size_q[63:32];
            OFF_CTRL:    rword_o = {18'd0, pend_q, err_q, done_q, req_q, 10'(cfg_q)};
            OFF_AUX_LO:  rword_o = aux_q[31:0];
            OFF_AUX_HI:  rword_o = aux_q[63:32];
            default:     rword_o = 32'd0;
        endcase
    end

    assign done_o = done_q;
    assign pend_o = pend_q;
    assign err_o  = err_q;

endmodule

// File: rtl/dec_commit_bank.sv
// Module dec_commit_bank
// Bank of NUM_DEC decoder slots behind a 32-bit word-addressed bus.
// Assumes ADDR_W is wide enough for (NUM_DEC+1)*8 words.
// Reads are combinational; writes take effect on the clock edge.
module dec_commit_bank
    import dcb_pkg::*;
#(
    parameter int NUM_DEC    = 4,
    parameter int TGT_CNT    = 4,
    parameter int CHK_CYCLES = 6,
    parameter bit SWITCH     = 1'b1,
    parameter bit IL_LO      = 1'b1,
    parameter bit IL_HI      = 1'b1,
    parameter int ADDR_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic [NUM_DEC-1:0] dec_committed
);

    localparam int SELW = ADDR_W - 3;

    logic [SELW-1:0]   sel;
    logic [2:0]        off;
    logic [NUM_DEC-1:0] done_v, pend_v, err_v;
    logic [31:0]       rword [NUM_DEC];
    logic [31:0]       cap_word;

    assign sel = addr[ADDR_W-1:3];
    assign off = addr[2:0];
    assign cap_word = {14'd0, IL_HI, IL_LO, 8'(TGT_CNT), 8'(NUM_DEC)};

    generate
        for (genvar i = 0; i < NUM_DEC; i++) begin : g_slot
            logic prev_d, next_d, wr_s;
            assign wr_s = wr_en && (sel == SELW'(i + 1));
            if (i == 0) begin : g_first
                assign prev_d = 1'b1;
            end else begin : g_mid
                assign prev_d = done_v[i-1];
            end
            if (i == NUM_DEC - 1) begin : g_last
                assign next_d = 1'b0;
            end else begin : g_nlast
                assign next_d = done_v[i+1];
            end
            dcb_slot #(
                .CHK_CYCLES(CHK_CYCLES), .TGT_CNT(TGT_CNT), .SWITCH(SWITCH)
            ) u_slot (
                .clk         (clk),
                .rst_n       (rst_n),
                .wr_i        (wr_s),
                .off_i       (off),
                .wdata_i     (wdata),
                .prev_done_i (prev_d),
                .next_done_i (next_d),
                .rword_o     (rword[i]),
                .done_o      (done_v[i]),
                .pend_o      (pend_v[i]),
                .err_o       (err_v[i])
            );
        end
    endgenerate

    // read mux over capability word and slot windows
    always_comb begin
        rdata = 32'd0;
        if (sel == '0 && off == 3'd0) rdata = cap_word;
        for (int i = 0; i < NUM_DEC; i++) begin
            if (sel == SELW'(i + 1)) rdata = rword[i];
        end
    end

    assign dec_committed = done_v;

endmodule

// File: rtl/dcb_chk.sv
// Module dcb_chk
// Protocol checker for dec_commit_bank, attached by bind.
// Assumes the default slot window layout (control at +4).
module dcb_chk #(
    parameter int NUM_DEC = 4,
    parameter int ADDR_W  = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  addr,
    input logic [NUM_DEC-1:0] done_v,
    input logic [NUM_DEC-1:0] pend_v,
    input logic [NUM_DEC-1:0] err_v
);

    generate
        for (genvar i = 0; i < NUM_DEC; i++) begin : g_c
            // R4
            state_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0({pend_v[i], done_v[i], err_v[i]}));
            // R4
            commit_after_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(done_v[i]) |-> $past(pend_v[i]));
            // R7
            err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (err_v[i] && !(wr_en && addr == ADDR_W'((i + 1) * 8 + 4))) |=> err_v[i]);
            if (i > 0) begin : g_ord
                // R5
                order_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    done_v[i] |-> done_v[i-1]);
            end
            if (i < NUM_DEC - 1) begin : g_rel
                // R8
                release_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    $fell(done_v[i]) |-> !$past(done_v[i+1]));
            end
        end
    endgenerate

endmodule

bind dec_commit_bank dcb_chk #(.NUM_DEC(NUM_DEC), .ADDR_W(ADDR_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .addr   (addr),
    .done_v (done_v),
    .pend_v (pend_v),
    .err_v  (err_v)
);

// File: tb/sim_dec_commit_bank.sv
`timescale 1ns/1ps
// Bench for dec_commit_bank: table walk then directed ordering tests.
module sim_dec_commit_bank;

    localparam int NDEC = 4;
    localparam int CHK  = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [NDEC-1:0] dec_committed;
    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] got;

    always #2 clk = ~clk;

    dec_commit_bank #(.NUM_DEC(NDEC), .TGT_CNT(4), .CHK_CYCLES(CHK)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .dec_committed(dec_committed)
    );

    // {write, address, data}
    localparam logic [40:0] VEC [0:16] = '{
        {1'b0, 8'd0,  32'h0003_0404},
        {1'b0, 8'd12, 32'h0000_0000},
        {1'b0, 8'd8,  32'h0000_0000},
        {1'b0, 8'd36, 32'h0000_0000},
        {1'b1, 8'd8,  32'h1000_0000},
        {1'b1, 8'd9,  32'h0000_0002},
        {1'b1, 8'd10, 32'h2000_0000},
        {1'b1, 8'd13, 32'h0403_0201},
        {1'b1, 8'd14, 32'h0807_0605},
        {1'b1, 8'd12, 32'h0000_0112},
        {1'b0, 8'd8,  32'h1000_0000},
        {1'b0, 8'd9,  32'h0000_0002},
        {1'b0, 8'd10, 32'h2000_0000},
        {1'b0, 8'd13, 32'h0403_0201},
        {1'b0, 8'd14, 32'h0807_0605},
        {1'b0, 8'd12, 32'h0000_0112},
        {1'b0, 8'd40, 32'h0000_0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a[5:0]; wdata = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a);
        @(negedge clk);
        addr = a[5:0];
        #1 got = rdata;
    endtask

    task automatic wait_chk();
        repeat (CHK + 1) @(posedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 R2 R3 table walk
        for (int k = 0; k < 17; k++) begin
            if (VEC[k][40]) wr(VEC[k][39:32], VEC[k][31:0]);
            else begin
                rd(VEC[k][39:32]);
                chk($sformatf("R1/R2/R3 entry %0d", k), got, VEC[k][31:0]);
            end
        end
        chk("R1 committed vector", 32'(dec_committed), 32'd0);

        // R4 commit latency on slot 0
        wr(8'd12, 32'h0000_0512);
        rd(8'd12); chk("R4 pending", got, 32'h0000_2512);
        repeat (CHK - 1) @(posedge clk);
        rd(8'd12); chk("R4 not early", got, 32'h0000_2512);
        @(posedge clk);
        rd(8'd12); chk("R4 committed", got, 32'h0000_0D12);
        chk("R4 vector", 32'(dec_committed), 32'h1);

        // R10 frozen while committed
        wr(8'd8, 32'h3000_0000);
        rd(8'd8); chk("R10 base frozen", got, 32'h1000_0000);
        wr(8'd12, 32'h0000_0400);
        rd(8'd12); chk("R10 cfg frozen", got, 32'h0000_0D12);

        // R5 slot 2 out of order
        wr(8'd26, 32'h1000_0000);
        wr(8'd28, 32'h0000_0400);
        wait_chk();
        rd(8'd28); chk("R5 order error", got, 32'h0000_1400);

        // R7 sticky error
        wr(8'd28, 32'h0000_0400);
        wait_chk();
        rd(8'd28); chk("R7 error held", got, 32'h0000_1400);
        wr(8'd28, 32'h0000_0000);
        rd(8'd28); chk("R7 error cleared", got, 32'h0000_0000);

        // R6 alignment and zero size on slot 1
        wr(8'd16, 32'h0800_0000);
        wr(8'd18, 32'h1000_0000);
        wr(8'd20, 32'h0000_0400);
        wait_chk();
        rd(8'd20); chk("R6 base unaligned", got, 32'h0000_1400);
        wr(8'd20, 32'h0000_0000);
        wr(8'd16, 32'h0000_0000);
        wr(8'd18, 32'h0000_0000);
        wr(8'd20, 32'h0000_0400);
        wait_chk();
        rd(8'd20); chk("R6 size zero", got, 32'h0000_1400);
        wr(8'd20, 32'h0000_0000);
        wr(8'd18, 32'h1000_0800);
        wr(8'd20, 32'h0000_0400);
        wait_chk();
        rd(8'd20); chk("R6 size unaligned", got, 32'h0000_1400);
        wr(8'd20, 32'h0000_0000);
        wr(8'd18, 32'h1000_0000);
        wr(8'd20, 32'h0000_0400);
        wait_chk();
        rd(8'd20); chk("R6 good commit", got, 32'h0000_0C00);

        // R11 way code limits on slot 2
        wr(8'd28, 32'h0000_0430);
        wait_chk();
        rd(8'd28); chk("R11 ways over targets", got, 32'h0000_1430);
        wr(8'd28, 32'h0000_0000);
        wr(8'd28, 32'h0000_0450);
        wait_chk();
        rd(8'd28); chk("R11 ways code invalid", got, 32'h0000_1450);
        wr(8'd28, 32'h0000_0000);
        wr(8'd28, 32'h0000_0420);
        wait_chk();
        rd(8'd28); chk("R11 four ways ok", got, 32'h0000_0C20);
        chk("R11 vector", 32'(dec_committed), 32'h7);

        // R8 release ordering
        wr(8'd20, 32'h0000_0000);
        rd(8'd20); chk("R8 release refused", got, 32'h0000_0C00);
        wr(8'd28, 32'h0000_0020);
        rd(8'd28); chk("R8 top released", got, 32'h0000_0020);
        wr(8'd20, 32'h0000_0000);
        rd(8'd20); chk("R8 next released", got, 32'h0000_0000);
        rd(8'd18); chk("R8 size kept", got, 32'h1000_0000);
        chk("R8 vector", 32'(dec_committed), 32'h1);

        // R9 lock on slot 1
        wr(8'd16, 32'h1000_0000);
        wr(8'd20, 32'h0000_0600);
        wait_chk();
        rd(8'd20); chk("R9 locked commit", got, 32'h0000_0E00);
        wr(8'd16, 32'h7000_0000);
        rd(8'd16); chk("R9 base locked", got, 32'h1000_0000);
        wr(8'd20, 32'h0000_0000);
        rd(8'd20); chk("R9 release blocked", got, 32'h0000_0E00);

        // R1 reset mid-run
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        rd(8'd20); chk("R1 ctrl after reset", got, 32'h0000_0000);
        rd(8'd16); chk("R1 base after reset", got, 32'h0000_0000);
        chk("R1 vector after reset", 32'(dec_committed), 32'd0);

        finish_run();
    end

endmodule